// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block holds wall-clock time and calendar date as packed BCD bytes behind a small byte-wide register bus. Eight clock locations cover hundredths, seconds, minutes, hours with a century flag pair, weekday, day of month, month and two-digit year. A ninth location at 08h stores a free control byte. A one-cycle tick input at 100 Hz advances the count, and the block carries every rollover through to the year. Month lengths and leap years are handled.

Software can stop the count with a bit kept beside the seconds. A read or write of any clock location holds the count still for that cycle, so a byte never changes under the bus. A tick that arrives during that cycle is kept and applied right after. A power-restore pulse sets a halt flag at address 0Ch. While that flag is set, the bus shows the time taken when the flag went high, and an internal copy keeps running. Clearing the flag makes the running time visible again.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After synchronous reset the clock reads 00:00:00.00 with weekday 01, date 01, month 01, year 00, and all flags clear. The control byte and the halt location read 00h.
- R2: Each applied tick adds one hundredth (address 00h). Hundredths roll 99→00 into seconds (address 01h bits 6:0), seconds roll 59→00 into minutes (address 02h bits 6:0), and minutes roll 59→00 into hours (address 03h bits 5:0). Hours run 00–23 and roll into the date.
- R3: Address 03h bit 7 enables the century bit, which is bit 6. When the enable is 1, the century bit inverts on a year rollover 99→00. When the enable is 0, the century bit keeps its value.
- R4: When the hours roll over, the weekday (address 04h bits 2:0) steps 1..7 and wraps 7→1, and the date (address 05h) steps. The last date of a month is 30 for months 04, 06, 09 and 11, 28 for February, 29 for February in a year divisible by 4, and 31 otherwise. Past that date the date returns to 01 and the month (address 06h) steps. Month 12 wraps to 01 and the year (address 07h) steps 99→00.
- R5: While address 01h bit 7 (stop) is 1, ticks are discarded and the time does not advance. Once stop is cleared, the next tick counts.
- R6: In a cycle that reads or writes any address 00h–07h, the count does not advance. A tick in such a cycle is held and applied in the first free cycle, so the read sees the value from before the tick.
- R7: A pulse on the power-restore input sets the halt flag (address 0Ch bit 6). While the flag is set, reads show the time captured at that moment and the internal count keeps running. Writing the flag to 0 exposes the running time.
- R8: Address 08h stores any byte written to it, reads it back, and has no effect on the time.
- R9: A digit above 9 that is written is kept as written. On the next step that digit counts as 9, and a field at or above its maximum wraps to its minimum.
- R10: Bits that a field does not use read as 0, for example address 02h bit 7. Addresses outside 00h–08h and 0Ch read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 100 Hz advance request |
| pwr_restore | input | 1 | Pulse after power returns from a failure; sets halt flag |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; freezes counting for the cycle |
| rd_data | output | 8 | Read byte, combinational from addr |

## Verification
A wrong carry or month-length decision inside the advance logic stays hidden until the field it drives is read. For that reason each rollover case is set up one tick before the boundary and read in the cycle right after the tick, so a fault shows up within two cycles. A lost or doubled deferred tick shows as the hundredths being off by one on the first read after a stall. A fault in the snapshot path shows up only when the halt flag is set or cleared, so both edges are read back directly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int CLK_REGS = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // every numeric field held as a full BCD byte; unused high bits stay 0
    typedef struct packed {
        logic  stop;
        logic  ceb;
        logic  cb;
        byte_t hund;
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t dow;
        byte_t date;
        byte_t month;
        byte_t year;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{
        stop: 1'b0, ceb: 1'b0, cb: 1'b0,
        hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
        dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00
    };

    // field at or past its limit (non-BCD values compare high)
    function automatic logic bcd_at_top(byte_t v, byte_t top);
        return v >= top;
    endfunction

    function automatic byte_t bcd_next(byte_t v, byte_t top, byte_t bottom);
        if (v >= top)
            return bottom;
        else if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return v + 8'd1;
    endfunction

    // last valid date of a month; year is BCD, leap when divisible by 4
    function automatic byte_t month_len(byte_t month, byte_t year);
        logic [1:0] mod4;
        mod4 = {year[4], 1'b0} + year[1:0];
        case (month)
            8'h02:                      return (mod4 == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t rtc_write(rtc_time_t t, logic [2:0] idx, byte_t b);
        rtc_time_t r;
        r = t;
        case (idx)
            3'd0: r.hund = b;
            3'd1: begin r.stop = b[7]; r.sec = {1'b0, b[6:0]}; end
            3'd2: r.min = {1'b0, b[6:0]};
            3'd3: begin r.ceb = b[7]; r.cb = b[6]; r.hour = {2'b0, b[5:0]}; end
            3'd4: r.dow = {5'b0, b[2:0]};
            3'd5: r.date = {2'b0, b[5:0]};
            3'd6: r.month = {3'b0, b[4:0]};
            default: r.year = b;
        endcase
        return r;
    endfunction

    function automatic byte_t rtc_read(rtc_time_t t, logic [2:0] idx);
        case (idx)
            3'd0: return t.hund;
            3'd1: return {t.stop, t.sec[6:0]};
            3'd2: return {1'b0, t.min[6:0]};
            3'd3: return {t.ceb, t.cb, t.hour[5:0]};
            3'd4: return {5'b0, t.dow[2:0]};
            3'd5: return {2'b0, t.date[5:0]};
            3'd6: return {3'b0, t.month[4:0]};
            default: return t.year;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic stop,
    input  logic busy,
    output logic step
);
    logic pending;

    assign step = !stop && !busy && (tick || pending);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (stop)
            pending <= 1'b0;
        else if (busy && tick)
            pending <= 1'b1;
        else if (step)
            pending <= 1'b0;
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic  w_hund, w_sec, w_min, w_hour, w_date, w_month, w_year;
    byte_t last_day;

    always_comb begin
        last_day = month_len(cur.month, cur.year);
        w_hund   = bcd_at_top(cur.hund, 8'h99);
        w_sec    = w_hund  && bcd_at_top(cur.sec, 8'h59);
        w_min    = w_sec   && bcd_at_top(cur.min, 8'h59);
        w_hour   = w_min   && bcd_at_top(cur.hour, 8'h23);
        w_date   = w_hour  && bcd_at_top(cur.date, last_day);
        w_month  = w_date  && bcd_at_top(cur.month, 8'h12);
        w_year   = w_month && bcd_at_top(cur.year, 8'h99);

        nxt      = cur;
        nxt.hund = bcd_next(cur.hund, 8'h99, 8'h00);
        if (w_hund)  nxt.sec   = bcd_next(cur.sec, 8'h59, 8'h00);
        if (w_sec)   nxt.min   = bcd_next(cur.min, 8'h59, 8'h00);
        if (w_min)   nxt.hour  = bcd_next(cur.hour, 8'h23, 8'h00);
        if (w_hour) begin
            nxt.dow  = bcd_next(cur.dow, 8'h07, 8'h01);
            nxt.date = bcd_next(cur.date, last_day, 8'h01);
        end
        if (w_date)  nxt.month = bcd_next(cur.month, 8'h12, 8'h01);
        if (w_month) nxt.year  = bcd_next(cur.year, 8'h99, 8'h00);
        if (w_year && cur.ceb) nxt.cb = ~cur.cb;
    end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 8,
    parameter int HALT_ADDR = 12,
    parameter int HALT_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pwr_restore,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] CLK_LIMIT = ADDR_W'(CLK_REGS);
    localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] HALT_A    = ADDR_W'(HALT_ADDR);

    rtc_time_t live, snap, adv, vis;
    byte_t     ctrl;
    logic      halt;
    logic      clk_hit, busy, step;

    assign clk_hit = addr < CLK_LIMIT;
    assign busy    = clk_hit && (rd_en || wr_en);

    rtc_tick_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .stop (live.stop),
        .busy (busy),
        .step (step)
    );

    rtc_advance u_adv (
        .cur (live),
        .nxt (adv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= RESET_TIME;
            snap <= RESET_TIME;
            halt <= 1'b0;
            ctrl <= '0;
        end else begin
            if (wr_en && clk_hit) begin
                live <= rtc_write(live, addr[2:0], wr_data);
                snap <= rtc_write(snap, addr[2:0], wr_data);
            end else if (step) begin
                live <= adv;
            end
            if (wr_en && addr == CTRL_A)
                ctrl <= wr_data;
            if (pwr_restore) begin
                halt <= 1'b1;
                snap <= live;
            end else if (wr_en && addr == HALT_A) begin
                halt <= wr_data[HALT_BIT];
                if (wr_data[HALT_BIT])
                    snap <= live;
            end
        end
    end

    always_comb begin
        vis     = halt ? snap : live;
        rd_data = '0;
        if (clk_hit)
            rd_data = rtc_read(vis, addr[2:0]);
        else if (addr == CTRL_A)
            rd_data = ctrl;
        else if (addr == HALT_A)
            rd_data[HALT_BIT] = halt;
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_restore,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input rtc_time_t         live,
    input rtc_time_t         snap,
    input logic              halt,
    input logic              step
);
    // R5: stop bit set and no write -> count frozen
    p_stop_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (live.stop && !wr_en) |=> $stable(live));

    // R5: the gate never advances while stopped
    p_step_gate_r5: assert property (@(posedge clk) disable iff (rst)
        step |-> !live.stop);

    // R6: a clock-address read holds the count for that cycle
    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr < ADDR_W'(CLK_REGS)) |=> $stable(live));

    // R3: century bit locked while its enable is clear
    p_cent_lock_r3: assert property (@(posedge clk) disable iff (rst)
        (!live.ceb && !wr_en) |=> $stable(live.cb));

    // R7: power-restore pulse sets the halt flag
    p_halt_set_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_restore |=> halt);

    // R7: visible copy holds while halted
    p_halt_snap_r7: assert property (@(posedge clk) disable iff (rst)
        (halt && !pwr_restore && !wr_en) |=> $stable(snap));
endmodule

bind bcd_rtc_regs rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_restore (pwr_restore),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .live        (live),
    .snap        (snap),
    .halt        (halt),
    .step        (step)
);

// File: tb/test_bcd_rtc_regs.sv
module test_bcd_rtc_regs;
    localparam int CLK_PER = 10;
    localparam int AW      = 4;

    typedef struct {
        logic [7:0] exp;
        logic [AW-1:0] a;
        string      req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          pwr_restore = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    bcd_rtc_regs #(.ADDR_W(AW)) i_bcd_rtc_regs (
        .clk(clk), .rst(rst), .tick(tick), .pwr_restore(pwr_restore),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    // monitor: compares each read cycle against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (rd_en) begin
                item_t it;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty: actual %02h expected none", rd_data);
                end else begin
                    it = q.pop_front();
                    if (rd_data !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr %0h: actual %02h expected %02h",
                                 it.req, it.a, rd_data, it.exp);
                    end
                end
            end
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [7:0] e, input string r);
        item_t it;
        it.exp = e; it.a = a; it.req = r;
        q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        push(a, e, r);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // 23:59:59.99 with given hour byte (carries century flags)
    task automatic end_of_day(input logic [7:0] hour_byte);
        wr(4'h0, 8'h99);
        wr(4'h1, 8'h59);
        wr(4'h2, 8'h59);
        wr(4'h3, hour_byte);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(4'h0, 8'h00, "R1"); rd(4'h1, 8'h00, "R1"); rd(4'h3, 8'h00, "R1");
        rd(4'h4, 8'h01, "R1"); rd(4'h5, 8'h01, "R1"); rd(4'h6, 8'h01, "R1");
        rd(4'h7, 8'h00, "R1"); rd(4'h8, 8'h00, "R1"); rd(4'hC, 8'h00, "R1");

        // R2 plain counting
        ticks(3);
        rd(4'h0, 8'h03, "R2");

        // R2 R3 R4 full rollover, century enabled
        end_of_day(8'hA3);
        wr(4'h4, 8'h07); wr(4'h5, 8'h31); wr(4'h6, 8'h12); wr(4'h7, 8'h99);
        ticks(1);
        rd(4'h0, 8'h00, "R2"); rd(4'h1, 8'h00, "R2"); rd(4'h2, 8'h00, "R2");
        rd(4'h3, 8'hC0, "R3"); rd(4'h4, 8'h01, "R4"); rd(4'h5, 8'h01, "R4");
        rd(4'h6, 8'h01, "R4"); rd(4'h7, 8'h00, "R4");

        // R3 century locked when enable clear
        end_of_day(8'h63);
        wr(4'h5, 8'h31); wr(4'h6, 8'h12); wr(4'h7, 8'h99);
        ticks(1);
        rd(4'h3, 8'h40, "R3"); rd(4'h7, 8'h00, "R3");

        // R4 leap February
        end_of_day(8'h23);
        wr(4'h4, 8'h03); wr(4'h5, 8'h28); wr(4'h6, 8'h02); wr(4'h7, 8'h24);
        ticks(1);
        rd(4'h5, 8'h29, "R4"); rd(4'h6, 8'h02, "R4"); rd(4'h4, 8'h04, "R4");
        // R4 non-leap February
        end_of_day(8'h23);
        wr(4'h5, 8'h28); wr(4'h7, 8'h23);
        ticks(1);
        rd(4'h5, 8'h01, "R4"); rd(4'h6, 8'h03, "R4");
        // R4 thirty-day month
        end_of_day(8'h23);
        wr(4'h5, 8'h30); wr(4'h6, 8'h04);
        ticks(1);
        rd(4'h5, 8'h01, "R4"); rd(4'h6, 8'h05, "R4");

        // R5 stop bit
        wr(4'h0, 8'h10); wr(4'h1, 8'h80);
        ticks(3);
        rd(4'h0, 8'h10, "R5"); rd(4'h1, 8'h80, "R5");
        wr(4'h1, 8'h00);
        ticks(1);
        rd(4'h0, 8'h11, "R5");

        // R6 read freeze with deferred tick
        wr(4'h0, 8'h40);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'h0; tick = 1'b1;
        push(4'h0, 8'h40, "R6");
        @(negedge clk);
        tick = 1'b0;
        push(4'h0, 8'h40, "R6");
        @(negedge clk);
        rd_en = 1'b0;
        rd(4'h0, 8'h41, "R6");

        // R7 halt flag
        wr(4'h0, 8'h20);
        @(negedge clk); pwr_restore = 1'b1;
        @(negedge clk); pwr_restore = 1'b0;
        rd(4'hC, 8'h40, "R7");
        ticks(3);
        rd(4'h0, 8'h20, "R7");
        wr(4'hC, 8'h00);
        rd(4'h0, 8'h23, "R7"); rd(4'hC, 8'h00, "R7");

        // R8 control byte
        wr(4'h8, 8'hA5);
        rd(4'h8, 8'hA5, "R8"); rd(4'h0, 8'h23, "R8");

        // R9 non-BCD digits
        wr(4'h0, 8'h0A);
        ticks(1);
        rd(4'h0, 8'h10, "R9");
        wr(4'h0, 8'h99); wr(4'h1, 8'h5C); wr(4'h2, 8'h00);
        ticks(1);
        rd(4'h1, 8'h00, "R9"); rd(4'h2, 8'h01, "R9");

        // R10 unused bits and addresses
        wr(4'h2, 8'hFF);
        rd(4'h2, 8'h7F, "R10"); rd(4'hA, 8'h00, "R10");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", q.size());
        end
        finish_run();
    end
endmodule